// File: doc/BRIEF.md
# Timer Capture Register Unit

This block records the instant of an external event by copying the value of a free-running 16-bit timer count into a capture register. The event is an active edge on one of two trigger inputs: a device pin, or the output of an on-chip comparator. A select input picks one of them. Each trigger input passes through a two-flop synchronizer before edge detection. An edge-select input decides whether rising or falling edges count. Every capture raises a capture flag. Software clears the flag by writing a one to it.

Software reaches the 16-bit capture register over an 8-bit register bus. One shared temporary latch holds the high byte, so a 16-bit access is seen as a single operation. On a read, the low-byte access snapshots the high byte into the latch. On a write, the high byte is parked in the latch and the low-byte write commits both bytes together. When the 4-bit waveform mode names a code in which the register serves as the counter's TOP value, the register becomes writable and capturing stops. The counter, the comparator and the interrupt logic sit outside the block.

Top module: `tcap_top`

## Requirements
- R1: After reset, the capture register reads 0x0000, the capture flag is 0 and the temporary high-byte latch is 0x00. The trigger synchronizers and the edge state reset to low.
- R2: The capture register loads `counterVal` on the third rising clock edge after the selected trigger input changes (two synchronizer flops, then the edge register). Only the active edge captures: rising when `edgeSel`=1, falling when `edgeSel`=0. The opposite edge leaves the register and the flag unchanged.
- R3: `srcSel`=0 selects `extTrig` and `srcSel`=1 selects `cmpOut`. Edges on the input that is not selected have no effect.
- R4: Changing `srcSel` while the two synchronized inputs differ is seen as an edge. If that edge has the active polarity, it captures the counter and sets the flag.
- R5: Every capture sets the capture flag. A bus write to address 2 with data bit 0 = 1 clears it, and a write with bit 0 = 0 leaves it unchanged. A capture in the same cycle as a clear leaves the flag set. A read of address 2 returns the flag in bit 0, with zeros in bits 7:1.
- R6: Each capture overwrites the capture register, even if software has not read the previous value.
- R7: A bus read of address 0 returns capture bits 7:0 and copies capture bits 15:8 into the temporary latch. A read of address 1 returns the latch, so a capture between the two reads does not change the high byte that is returned.
- R8: A bus write to address 1 loads the temporary latch. A bus write to address 0 in a TOP mode commits {latch, data} to the capture register, which is visible on `capReg` one cycle later.
- R9: In a mode that is not a TOP mode, a write to address 0 leaves the capture register unchanged.
- R10: With the default parameters, the TOP modes are the `waveMode` codes 8, 10, 12 and 14. In a TOP mode no edge causes a capture or sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| counterVal | input | 16 | Current timer count |
| extTrig | input | 1 | External trigger pin |
| cmpOut | input | 1 | Comparator output used as trigger |
| srcSel | input | 1 | Trigger source: 0 pin, 1 comparator |
| edgeSel | input | 1 | Active edge: 1 rising, 0 falling |
| waveMode | input | 4 | Waveform generation mode code |
| busAddr | input | 2 | Register address: 0 low byte, 1 high byte, 2 flag |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for the current address |
| capFlag | output | 1 | Capture flag |
| capReg | output | 16 | Capture register, also the TOP value |

## Verification
The bench checks the exact capture latency. A design that skipped or doubled a synchronizer stage would flag one cycle early or late. It reads the high byte after a second capture that lands between the two byte reads: a design that read the high byte live, without the latch, would return a mixed value. It times a flag clear to land in the same cycle as a capture, and it switches sources while the two inputs differ. A wrong priority would lose the event, and a gated mux would miss the spurious capture. Low-byte writes in a capture mode, and edges in a TOP mode, must both leave the register untouched.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
  typedef struct packed {
    logic capture;
    logic tempFromCap;
    logic tempFromBus;
    logic commitWrite;
    logic clearFlag;
  } tcap_strobe_t;

  localparam logic [1:0] ADDR_LO   = 2'd0;
  localparam logic [1:0] ADDR_HI   = 2'd1;
  localparam logic [1:0] ADDR_FLAG = 2'd2;
endpackage

// File: rtl/tcap_sync.sv
module tcap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/tcap_ctrl.sv
module tcap_ctrl
  import tcap_pkg::*;
#(
  parameter int          MODE_W   = 4,
  parameter int          SYNC_N   = 2,
  parameter logic [(1<<MODE_W)-1:0] TOP_MASK = 16'h5500
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extTrig,
  input  logic              cmpOut,
  input  logic              srcSel,
  input  logic              edgeSel,
  input  logic [MODE_W-1:0] waveMode,
  input  logic [1:0]        busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic              wrBit0,
  output tcap_strobe_t      strb
);
  localparam int NUM_SRC = 2;

  logic [NUM_SRC-1:0] trigRaw;
  logic [NUM_SRC-1:0] trigSync;
  logic selLevel;
  logic prevLevel;
  logic topMode;
  logic activeEdge;

  assign trigRaw = {cmpOut, extTrig};

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_sync
    tcap_sync #(.STAGES(SYNC_N)) u_sync (
      .clk (clk),
      .rstN(rstN),
      .din (trigRaw[s]),
      .dout(trigSync[s])
    );
  end

  // The mux sits after the synchronizers, so a source switch shows up as an edge
  assign selLevel = trigSync[srcSel];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLevel <= 1'b0;
    else       prevLevel <= selLevel;
  end

  assign topMode    = TOP_MASK[waveMode];
  assign activeEdge = edgeSel ? (selLevel & ~prevLevel) : (~selLevel & prevLevel);

  always_comb begin
    strb             = '0;
    strb.capture     = activeEdge & ~topMode;
    strb.tempFromCap = busRd & (busAddr == ADDR_LO);
    strb.tempFromBus = busWr & (busAddr == ADDR_HI);
    strb.commitWrite = busWr & (busAddr == ADDR_LO) & topMode;
    strb.clearFlag   = busWr & (busAddr == ADDR_FLAG) & wrBit0;
  end

  // R2: a capture needs the edge register to disagree with the selected level
  assert_capture_needs_change_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |-> (selLevel != prevLevel));

  // R4: a change of source with unequal synchronized inputs is an edge on the next cycle
  assert_switch_edge_R4: assert property (@(posedge clk) disable iff (!rstN)
    (srcSel != $past(srcSel)) && $stable(trigSync) && (trigSync[0] != trigSync[1])
      |-> (selLevel != prevLevel));
endmodule

// File: rtl/tcap_datapath.sv
module tcap_datapath
  import tcap_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  tcap_strobe_t      strb,
  input  logic [CNT_W-1:0]  counterVal,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              capFlag,
  output logic [CNT_W-1:0]  capReg
);
  localparam int HI_LSB = CNT_W - DATA_W;

  logic [DATA_W-1:0] tempHi;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 capReg <= '0;
    else if (strb.commitWrite) capReg <= {tempHi, busWdata};
    else if (strb.capture)     capReg <= counterVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 tempHi <= '0;
    else if (strb.tempFromCap) tempHi <= capReg[CNT_W-1:HI_LSB];
    else if (strb.tempFromBus) tempHi <= busWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               capFlag <= 1'b0;
    else if (strb.capture)   capFlag <= 1'b1;
    else if (strb.clearFlag) capFlag <= 1'b0;
  end

  always_comb begin
    case (busAddr)
      ADDR_LO:   busRdata = capReg[DATA_W-1:0];
      ADDR_HI:   busRdata = tempHi;
      ADDR_FLAG: busRdata = {{(DATA_W-1){1'b0}}, capFlag};
      default:   busRdata = '0;
    endcase
  end

  assert_capture_loads_count_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture && !strb.commitWrite |=> capReg == $past(counterVal));

  assert_flag_sets_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> capFlag);

  assert_flag_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearFlag && !strb.capture |=> !capFlag);

  assert_commit_pair_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.commitWrite |=> capReg == {$past(tempHi), $past(busWdata)});

  assert_temp_snapshot_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.tempFromCap |=> tempHi == $past(capReg[CNT_W-1:HI_LSB]));

  assert_reg_holds_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture && !strb.commitWrite |=> $stable(capReg));
endmodule

// File: rtl/tcap_top.sv
module tcap_top
  import tcap_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int MODE_W = 4,
  parameter int SYNC_N = 2,
  parameter logic [(1<<MODE_W)-1:0] TOP_MASK = 16'h5500
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2*DATA_W-1:0] counterVal,
  input  logic                extTrig,
  input  logic                cmpOut,
  input  logic                srcSel,
  input  logic                edgeSel,
  input  logic [MODE_W-1:0]   waveMode,
  input  logic [1:0]          busAddr,
  input  logic                busWr,
  input  logic                busRd,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  output logic                capFlag,
  output logic [2*DATA_W-1:0] capReg
);
  localparam int CNT_W = 2 * DATA_W;

  tcap_strobe_t strb;

  tcap_ctrl #(
    .MODE_W  (MODE_W),
    .SYNC_N  (SYNC_N),
    .TOP_MASK(TOP_MASK)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .extTrig (extTrig),
    .cmpOut  (cmpOut),
    .srcSel  (srcSel),
    .edgeSel (edgeSel),
    .waveMode(waveMode),
    .busAddr (busAddr),
    .busWr   (busWr),
    .busRd   (busRd),
    .wrBit0  (busWdata[0]),
    .strb    (strb)
  );

  tcap_datapath #(
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .counterVal(counterVal),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .capFlag   (capFlag),
    .capReg    (capReg)
  );

  // R10: in a TOP mode only a low-byte write may change the register
  assert_top_no_capture_R10: assert property (@(posedge clk) disable iff (!rstN)
    TOP_MASK[waveMode] && !(busWr && busAddr == ADDR_LO) |=> $stable(capReg));

  assert_top_flag_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    TOP_MASK[waveMode] && !capFlag |=> !capFlag);

  // R9: outside TOP modes a low-byte write with no capture leaves the register alone
  assert_write_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    !TOP_MASK[waveMode] && busWr && busAddr == ADDR_LO && !strb.capture |=> $stable(capReg));
endmodule

// File: tb/test_tcap_top.sv
`timescale 1ns/1ps
module test_tcap_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] counterVal = '0;
  logic        extTrig = 1'b0, cmpOut = 1'b0, srcSel = 1'b0, edgeSel = 1'b1;
  logic [3:0]  waveMode = 4'd0;
  logic [1:0]  busAddr = '0;
  logic        busWr = 1'b0, busRd = 1'b0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  logic        capFlag;
  logic [15:0] capReg;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  tcap_top i_tcap_top (
    .clk(clk), .rstN(rstN), .counterVal(counterVal), .extTrig(extTrig), .cmpOut(cmpOut),
    .srcSel(srcSel), .edgeSel(edgeSel), .waveMode(waveMode), .busAddr(busAddr),
    .busWr(busWr), .busRd(busRd), .busWdata(busWdata), .busRdata(busRdata),
    .capFlag(capFlag), .capReg(capReg)
  );

  function automatic bit isTopMode(input logic [3:0] m);
    return (m == 4'd8) || (m == 4'd10) || (m == 4'd12) || (m == 4'd14);
  endfunction

  function automatic logic [3:0] pickCaptureMode(input logic [31:0] r);
    logic [3:0] m = r[3:0];
    if (isTopMode(m)) m = m + 4'd1;
    return m;
  endfunction

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic read16(output logic [15:0] v);
    logic [7:0] lo, hi;
    busRead(2'd0, lo);
    busRead(2'd1, hi);
    v = {hi, lo};
  endtask

  task automatic setSel(input logic v);
    if (srcSel) cmpOut = v; else extTrig = v;
  endtask

  initial begin
    logic [15:0] v;
    logic [7:0]  b;
    logic [15:0] expVal;
    void'($urandom(32'd24681));

    waitCycles(3);
    #1;
    check(capReg == 16'h0 && capFlag == 1'b0, "R1 reset reg/flag", {capFlag, capReg[14:0]}, 16'h0);
    rstN = 1'b1;
    waitCycles(2);
    busRead(2'd1, b);
    check(b == 8'h00, "R1 reset temp latch", {8'h0, b}, 16'h0);

    // R2 latency: rising edge on the pin
    counterVal = 16'h1234;
    extTrig = 1'b1;
    waitCycles(2);
    check(capFlag == 1'b0, "R2 no capture before third edge", {15'h0, capFlag}, 16'h0);
    waitCycles(1);
    check(capFlag == 1'b1 && capReg == 16'h1234, "R2 capture on third edge", capReg, 16'h1234);
    busWrite(2'd2, 8'h00);
    check(capFlag == 1'b1, "R5 write zero keeps flag", {15'h0, capFlag}, 16'h1);
    busWrite(2'd2, 8'h01);
    check(capFlag == 1'b0, "R5 write one clears flag", {15'h0, capFlag}, 16'h0);

    // R2 opposite edge ignored
    counterVal = 16'hAAAA;
    extTrig = 1'b0;
    waitCycles(5);
    check(capFlag == 1'b0 && capReg == 16'h1234, "R2 falling edge ignored when rising selected", capReg, 16'h1234);

    // R3 unselected input ignored
    cmpOut = 1'b1;
    waitCycles(5);
    cmpOut = 1'b0;
    waitCycles(5);
    check(capFlag == 1'b0 && capReg == 16'h1234, "R3 comparator ignored while pin selected", capReg, 16'h1234);

    // R4 source switch with differing levels
    cmpOut = 1'b1;
    waitCycles(5);
    counterVal = 16'h0F0F;
    srcSel = 1'b1;
    waitCycles(4);
    check(capFlag == 1'b1 && capReg == 16'h0F0F, "R4 source switch captures", capReg, 16'h0F0F);
    busWrite(2'd2, 8'h01);

    // R5 capture and clear in the same cycle
    edgeSel = 1'b0;
    counterVal = 16'h5A5A;
    cmpOut = 1'b0;
    waitCycles(2);
    busWrite(2'd2, 8'h01);
    check(capFlag == 1'b1 && capReg == 16'h5A5A, "R5 capture wins over clear", {15'h0, capFlag}, 16'h1);
    busRead(2'd2, b);
    check(b == 8'h01, "R5 flag readback", {8'h0, b}, 16'h1);
    busWrite(2'd2, 8'h01);

    // R6 overwrite without read, R7 latched high byte
    edgeSel = 1'b1;
    counterVal = 16'h1122;
    cmpOut = 1'b1;
    waitCycles(5);
    counterVal = 16'h3344;
    cmpOut = 1'b0;
    waitCycles(5);
    busRead(2'd0, b);
    check(b == 8'h22, "R7 low byte read", {8'h0, b}, 16'h22);
    cmpOut = 1'b1;
    waitCycles(5);
    busRead(2'd1, b);
    check(b == 8'h11, "R7 high byte from latch", {8'h0, b}, 16'h11);
    check(capReg == 16'h3344, "R6 overwrite by new capture", capReg, 16'h3344);
    read16(v);
    check(v == 16'h3344, "R7 paired read", v, 16'h3344);

    // R9 write ignored outside TOP mode
    waveMode = 4'd4;
    busWrite(2'd1, 8'hDE);
    busWrite(2'd0, 8'hAD);
    check(capReg == 16'h3344, "R9 write ignored in capture mode", capReg, 16'h3344);

    // R8 TOP-mode write, R10 no capture in TOP mode
    waveMode = 4'd14;
    busWrite(2'd1, 8'hAB);
    busWrite(2'd0, 8'hCD);
    check(capReg == 16'hABCD, "R8 paired write commits", capReg, 16'hABCD);
    busWrite(2'd2, 8'h01);
    counterVal = 16'h7777;
    cmpOut = 1'b0;
    waitCycles(5);
    cmpOut = 1'b1;
    waitCycles(5);
    check(capReg == 16'hABCD && capFlag == 1'b0, "R10 no capture in TOP mode", capReg, 16'hABCD);
    waveMode = 4'd10;
    busWrite(2'd1, 8'h01);
    busWrite(2'd0, 8'h02);
    read16(v);
    check(v == 16'h0102, "R8 readback after write, mode 10", v, 16'h0102);

    // Random captures
    for (int i = 0; i < 60; i++) begin
      logic activeLvl;
      waveMode = pickCaptureMode($urandom);
      srcSel   = 1'($urandom);
      edgeSel  = 1'($urandom);
      activeLvl = edgeSel;
      setSel(~activeLvl);
      waitCycles(5);
      busWrite(2'd2, 8'h01);
      expVal = 16'($urandom);
      counterVal = expVal;
      setSel(activeLvl);
      if (srcSel) extTrig = 1'($urandom); else cmpOut = 1'($urandom);
      waitCycles(5);
      read16(v);
      check(capFlag == 1'b1 && v == expVal, "R2 random capture", v, expVal);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog R2 actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule